// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter. Its count rate comes from the system clock divided by four and then by a selectable prescale ratio. The counter is compared with a writable period value. When the count equals the period, the next counted tick returns the counter to zero instead of advancing it. That same tick produces a one-cycle match pulse, which leaves the block directly for use as a serial shift-clock source. The match pulse also feeds a programmable postscaler. Every Nth match sets a sticky interrupt flag, and the interrupt line is raised while both the flag and its enable are set.

Software reaches four byte-wide registers through a simple synchronous write port and a combinational read port. Address 0 holds the count, address 1 the period, address 2 the control byte, and address 3 the interrupt flag and enable.

Top module: `period_timer`

## Requirements
- R1: After reset, count reads 00h, period reads FFh, control reads 00h, address 3 reads 00h, and `match_out` and `irq` are low.
- R2: While running, the count advances once every 4*P system clocks, counted from the clock edge that applied the last write to count or control. P is 1 for control[1:0]=00, 4 for 01, and 16 for 10 or 11.
- R3: On a tick where the count equals the period, the count becomes 00h. `match_out` is high for exactly the following clock cycle, aligned with the count reading 00h.
- R4: The flag (address 3 bit 0) is set on every (control[6:3]+1)-th match, counted from the last write to count or control.
- R5: `irq` is high exactly when the flag (address 3 bit 0) and the enable (address 3 bit 1) are both 1. Both bits are written and read at address 3.
- R6: The flag stays set until software writes address 3 with bit 0 = 0. If a postscaler set falls on the same edge as such a clearing write, the flag ends up set.
- R7: Addresses 0, 1 and 2 read back what was written. Control bit 7 always reads 0.
- R8: With control bit 2 (run) at 0, the count, prescaler and postscaler hold their values and `match_out` stays low.
- R9: A write to count or control restarts the prescale and postscale counts. A count write on the same edge as a tick takes precedence.
- R10: If the count is above the period, the counter passes through FFh to 00h without a match, then matches the period on the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Write strobe, applied at the rising edge |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| match_out | output | 1 | One-cycle pulse per period match (shift-clock source) |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
Two events can land on the same clock edge. A software write that clears the flag can coincide with the postscaler setting it. A software write to the count can coincide with a prescaler tick. The bench computes the exact edge of each event from the restart point that the control write defines, and it times a write to land on that edge. The flag must read 1 afterwards, and the count must read the written value, with the next tick one full prescale interval later. A sweep over prescale, period and postscale settings then compares count, pulse totals and flag state against closed-form arithmetic, one cycle before and some cycles after the first postscaler event.

// File: rtl/period_timer.sv
module period_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       match_out,
  output logic       irq
);

  logic [7:0] cnt, per;
  logic [6:0] ctl;
  logic [5:0] pre;
  logic [3:0] post;
  logic       flag, en;

  wire on      = ctl[2];
  wire wr_cnt  = wr && addr == 2'd0;
  wire wr_per  = wr && addr == 2'd1;
  wire wr_ctl  = wr && addr == 2'd2;
  wire wr_irq  = wr && addr == 2'd3;
  wire restart = wr_cnt || wr_ctl;

  wire [5:0] pre_lim = (ctl[1:0] == 2'd0) ? 6'd3 :
                       (ctl[1:0] == 2'd1) ? 6'd15 : 6'd63;

  wire tick      = on && !restart && pre == pre_lim;
  wire hit       = tick && cnt == per;
  wire post_done = hit && post == ctl[6:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= 8'h00;
      per       <= 8'hFF;
      ctl       <= 7'h00;
      pre       <= 6'd0;
      post      <= 4'd0;
      flag      <= 1'b0;
      en        <= 1'b0;
      match_out <= 1'b0;
    end else begin
      match_out <= hit;

      if (wr_cnt)     cnt <= wdata;
      else if (tick)  cnt <= hit ? 8'h00 : cnt + 8'd1;

      if (wr_per) per <= wdata;
      if (wr_ctl) ctl <= wdata[6:0];

      if (restart)    pre <= 6'd0;
      else if (on)    pre <= tick ? 6'd0 : pre + 6'd1;

      if (restart)    post <= 4'd0;
      else if (hit)   post <= post_done ? 4'd0 : post + 4'd1;

      if (wr_irq) en <= wdata[1];
      flag <= post_done || (wr_irq ? wdata[0] : flag);
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt;
      2'd1:    rdata = per;
      2'd2:    rdata = {1'b0, ctl};
      default: rdata = {6'd0, en, flag};
    endcase
  end

  assign irq = flag && en;

endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] cnt,
  input logic [6:0] ctl,
  input logic       flag,
  input logic       match_out
);

  p_pulse_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_out |-> cnt == 8'h00);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1 || cnt == 8'h00));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr && addr == 2'd3)) |=> flag);

  p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[2] && !wr) |=> ($stable(cnt) && !match_out));

  p_ctl_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd2 |-> !rdata[7]);

endmodule

bind period_timer period_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .rdata(rdata),
  .cnt(cnt), .ctl(ctl), .flag(flag), .match_out(match_out)
);

// File: tb/tb_period_timer.sv
module tb_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       match_out, irq;

  int total = 0, bad = 0, np = 0, base = 0;
  bit done = 0;

  always #10 clk = ~clk;

  period_timer dut (.*);

  always @(negedge clk) if (match_out) np++;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rreg(2'd0, v); chk("R1 count", v, 0);
    rreg(2'd1, v); chk("R1 period", v, 255);
    rreg(2'd2, v); chk("R1 control", v, 0);
    rreg(2'd3, v); chk("R1 irqreg", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 match", int'(match_out), 0);

    wreg(2'd1, 8'hA5); rreg(2'd1, v); chk("R7 period rw", v, 8'hA5);
    wreg(2'd2, 8'hB3); rreg(2'd2, v); chk("R7 ctl msb", v, 8'h33);
    wreg(2'd2, 8'h00);
    wreg(2'd0, 8'h5C); rreg(2'd0, v); chk("R7 count rw", v, 8'h5C);

    wreg(2'd3, 8'h03); chk("R5 irq both", int'(irq), 1);
    wreg(2'd3, 8'h01); chk("R5 irq no en", int'(irq), 0);
    rreg(2'd3, v); chk("R5 flag bit", v, 1);
    wreg(2'd3, 8'h02); chk("R5 irq no flag", int'(irq), 0);
    rreg(2'd3, v); chk("R5 en bit", v, 2);

    // R2 R3 R4 sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int qi = 0; qi < 2; qi++) begin
          int p, q, l, n1, n2, t;
          p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
          q = (qi == 0) ? 0 : 2;
          l = 4 * ((ps == 0) ? 1 : (ps == 1) ? 4 : 16);
          wreg(2'd2, 8'((q << 3) | ps));
          wreg(2'd0, 8'h00);
          wreg(2'd3, 8'h00);
          wreg(2'd1, 8'(p));
          wreg(2'd2, 8'((q << 3) | 4 | ps));
          #1; base = np;
          n1 = (p + 1) * l * (q + 1) - 1;
          wait_n(n1);
          t = n1 / l;
          rreg(2'd0, v); chk("R2 count", v, t % (p + 1));
          chk("R3 pulses", np - base, t / (p + 1));
          rreg(2'd3, v); chk("R4 flag early", v, 0);
          n2 = n1 + 1 + l + 2;
          wait_n(n2 - n1);
          t = n2 / l;
          rreg(2'd0, v); chk("R2 count late", v, t % (p + 1));
          chk("R3 pulses late", np - base, t / (p + 1));
          rreg(2'd3, v); chk("R4 flag set", v, ((t / (p + 1)) >= (q + 1)) ? 1 : 0);
        end
      end
    end

    // R6: clear lands on the set edge
    wreg(2'd2, 8'h00); wreg(2'd0, 8'h00); wreg(2'd1, 8'h01);
    wreg(2'd3, 8'h02);
    wreg(2'd2, 8'h04);
    repeat (6) @(negedge clk);
    wreg(2'd3, 8'h02);
    #1;
    rreg(2'd3, v); chk("R6 set wins", v, 3);
    chk("R6 irq", int'(irq), 1);
    wreg(2'd3, 8'h02);
    #1;
    rreg(2'd3, v); chk("R6 clear", v, 2);
    wreg(2'd2, 8'h00);

    // R9: count write on tick edge
    wreg(2'd1, 8'hFF); wreg(2'd0, 8'h00);
    wreg(2'd2, 8'h04);
    repeat (2) @(negedge clk);
    wreg(2'd0, 8'h40);
    #1;
    rreg(2'd0, v); chk("R9 write wins", v, 8'h40);
    wait_n(3); rreg(2'd0, v); chk("R9 hold", v, 8'h40);
    wait_n(1); rreg(2'd0, v); chk("R9 next", v, 8'h41);

    // R9: prescale restart mid-interval
    wreg(2'd2, 8'h06);
    repeat (28) @(negedge clk);
    wreg(2'd0, 8'h05);
    wait_n(63); rreg(2'd0, v); chk("R9 pre restart", v, 5);
    wait_n(1);  rreg(2'd0, v); chk("R9 pre tick", v, 6);

    // R8: stopped timer holds
    wreg(2'd2, 8'h00); wreg(2'd1, 8'h00); wreg(2'd0, 8'h07);
    wreg(2'd2, 8'h04);
    wait_n(10);
    wreg(2'd2, 8'h00);
    #1; base = np;
    rreg(2'd0, v);
    begin
      int held;
      held = v;
      wait_n(100);
      rreg(2'd0, v); chk("R8 count held", v, held);
      chk("R8 no pulses", np - base, 0);
    end

    // R10: period below count
    wreg(2'd1, 8'hFF); wreg(2'd0, 8'd20); wreg(2'd1, 8'd5);
    wreg(2'd2, 8'h04);
    #1; base = np;
    wait_n(40);  rreg(2'd0, v); chk("R10 counts up", v, 30);
    chk("R10 no match", np - base, 0);
    wait_n(924); rreg(2'd0, v); chk("R10 after wrap", v, 5);
    chk("R10 no match yet", np - base, 0);
    wait_n(4);   rreg(2'd0, v); chk("R10 match wrap", v, 0);
    chk("R10 one match", np - base, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule